// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Generator

This block produces a square wave whose frequency and duty cycle are set independently. A phase accumulator adds a frequency word on every enabled clock and wraps modulo 2^ACC_W, so the output frequency is `f_clk * word / 2^ACC_W`. The duty cycle comes from comparing only the most significant CMP_W bits of the accumulator against a threshold. The output is low whenever those bits exceed the threshold, and high otherwise.

A frequency word and a threshold are captured together by a load strobe. They are held as pending values and take over only at the next accumulator wrap, so a period is never cut short or stretched by a mid-cycle write. While the block is disabled, pending values take effect at once. This gives software a clean way to start the block from any setting, including leaving a zero frequency word.

The accumulator width is a parameter: 32 bits by default, or narrower (for example 24) to save area and shorten the carry chain. The edge positions jitter by at most one clock from period to period.

Top module: `pa_pwm_gen`

## Requirements
- R1: On every clock with `en` high, the accumulator adds the active frequency word modulo 2^ACC_W; with word 2^(ACC_W-4) a wrap occurs exactly every 16 enabled clocks.
- R2: `wrap_pulse` is high for the one clock that follows an enabled add that carried out of the accumulator's top bit, and is low otherwise.
- R3: `wave_out` is a register. After an enabled clock it is 0 if the top CMP_W bits of the updated accumulator, read as unsigned, are greater than the active threshold, and 1 otherwise.
- R4: A clock with `load` high captures `freq_word` and `thr_word` as pending values. While enabled, pending values become active only on a clock whose add carries. A load on that same clock stays pending for the following wrap.
- R5: With `en` low, the accumulator holds its value, `wave_out` and `wrap_pulse` are 0 after the clock, and any pending values become active at once.
- R6: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the active and pending values, `wave_out` and `wrap_pulse` to 0.
- R7: An active threshold of all ones holds `wave_out` at 1 on every enabled clock.
- R8: An active frequency word of 0 freezes the accumulator, so `wave_out` stays at its present level and no wrap occurs.
- R9: ACC_W (default 32) may be reduced, for example to 24. CMP_W (default 8) must not exceed ACC_W, and behaviour follows R1 to R8 at any such width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| freq_word | input | ACC_W | Phase increment, captured by `load` |
| thr_word | input | CMP_W | Duty threshold, captured by `load` |
| load | input | 1 | Capture strobe for both words |
| wave_out | output | 1 | Registered square wave |
| wrap_pulse | output | 1 | One-clock pulse after each accumulator wrap |

## Verification
The hardest case to reach is a load that arrives on the very clock in which the accumulator wraps while an earlier load is still pending. Here the old pending values must switch in, and the new ones must wait a full period. The stimulus issues loads at random cycles, at high wrap rates, with the enable toggling between them. A behavioural model tracks the accumulator, the pending values and the active values, so every such overlap is checked clock by clock. Both a 32-bit and a 24-bit instance receive the same stimulus.

// File: rtl/pa_pwm_gen.sv
module pa_pwm_gen #(
  parameter int ACC_W = 32,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [CMP_W-1:0] thr_word,
  input  logic             load,
  output logic             wave_out,
  output logic             wrap_pulse
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] acc, act_freq, pend_freq;
  logic [CMP_W-1:0] act_thr, pend_thr;
  logic             pend_vld;

  logic [ACC_W:0]   sum;
  logic             carry, apply;
  logic [ACC_W-1:0] acc_nxt;
  logic [CMP_W-1:0] thr_nxt;

  assign sum     = {1'b0, acc} + {1'b0, act_freq};
  assign carry   = en & sum[ACC_W];
  assign acc_nxt = en ? sum[ACC_W-1:0] : acc;
  assign apply   = pend_vld & (carry | ~en);
  assign thr_nxt = apply ? pend_thr : act_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      act_freq   <= '0;
      act_thr    <= '0;
      pend_freq  <= '0;
      pend_thr   <= '0;
      pend_vld   <= 1'b0;
      wave_out   <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      acc        <= acc_nxt;
      wrap_pulse <= carry;
      wave_out   <= en & (acc_nxt[TOP -: CMP_W] <= thr_nxt);
      if (apply) begin
        act_freq <= pend_freq;
        act_thr  <= pend_thr;
      end
      if (load) begin
        pend_freq <= freq_word;
        pend_thr  <= thr_word;
        pend_vld  <= 1'b1;
      end else if (apply) begin
        pend_vld  <= 1'b0;
      end
    end
  end

  p_idle_outputs_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!wave_out && !wrap_pulse));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

  p_apply_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !carry) |=> ($stable(act_freq) && $stable(act_thr)));

  p_freeze_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (en && act_freq == '0 && !pend_vld) |=> ($stable(acc) && !wrap_pulse));

  p_all_ones_high_r7: assert property (@(posedge clk) disable iff (rst)
    (en && act_thr == '1 && !pend_vld) |=> wave_out);

  p_wave_level_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !pend_vld) |=> (wave_out == (acc[TOP -: CMP_W] <= act_thr)));
endmodule

// File: tb/tb_pa_pwm_gen.sv
module tb_pa_pwm_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] freq_word = '0;
  logic [7:0]  thr_word = '0;
  logic        load = 1'b0;
  logic        wave_w, wrap_w, wave_n, wrap_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R6";

  always #5 clk = ~clk;

  pa_pwm_gen #(.ACC_W(32), .CMP_W(8)) dut (
    .clk(clk), .rst(rst), .en(en), .freq_word(freq_word), .thr_word(thr_word),
    .load(load), .wave_out(wave_w), .wrap_pulse(wrap_w));

  pa_pwm_gen #(.ACC_W(24), .CMP_W(8)) dut_narrow (
    .clk(clk), .rst(rst), .en(en), .freq_word(freq_word[23:0]), .thr_word(thr_word),
    .load(load), .wave_out(wave_n), .wrap_pulse(wrap_n));

  // behavioural model, index 0 = 32-bit, 1 = 24-bit
  longint unsigned m_acc[2], m_af[2], m_pf[2];
  int unsigned     m_at[2], m_pt[2];
  bit              m_pv[2], m_wave[2], m_wrap[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      int w;
      longint unsigned mask, s;
      bit c, ap;
      int unsigned tn;
      w = (i == 0) ? 32 : 24;
      mask = (64'd1 << w) - 1;
      if (rst) begin
        m_acc[i] = 0; m_af[i] = 0; m_pf[i] = 0; m_at[i] = 0; m_pt[i] = 0;
        m_pv[i] = 0; m_wave[i] = 0; m_wrap[i] = 0;
      end else begin
        c = 0;
        if (en) begin
          s = m_acc[i] + m_af[i];
          c = (s > mask);
          m_acc[i] = s & mask;
          ap = c && m_pv[i];
        end else ap = m_pv[i];
        tn = ap ? m_pt[i] : m_at[i];
        if (ap) begin m_af[i] = m_pf[i]; m_at[i] = m_pt[i]; end
        if (load) begin
          m_pf[i] = freq_word & mask; m_pt[i] = thr_word; m_pv[i] = 1;
        end else if (ap) m_pv[i] = 0;
        m_wave[i] = en && ((m_acc[i] >> (w - 8)) <= tn);
        m_wrap[i] = c;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(wave_w == m_wave[0], {req, " wave32"}, wave_w, m_wave[0]);
      chk(wrap_w == m_wrap[0], {req, " wrap32"}, wrap_w, m_wrap[0]);
      chk(wave_n == m_wave[1], {req, " wave24 R9"}, wave_n, m_wave[1]);
      chk(wrap_n == m_wrap[1], {req, " wrap24 R9"}, wrap_n, m_wrap[1]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [31:0] f, input logic [7:0] t);
    @(negedge clk);
    freq_word = f; thr_word = t; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int wraps;
    bit lvl;
    cyc(3);
    @(posedge clk); #2;
    chk(wave_w == 0 && wrap_w == 0, "R6 reset outputs", {wave_w, wrap_w}, 0);
    @(negedge clk); rst = 1'b0;

    // R1: period count, word 2^28 -> wrap every 16 clocks
    req = "R1";
    do_load(32'h1000_0000, 8'h7F);
    @(negedge clk); en = 1'b1;
    wraps = 0;
    repeat (64) begin @(posedge clk); #3; wraps += wrap_w; end
    chk(wraps == 4, "R1 wrap count", wraps, 4);

    // R3/R2: duty sweep
    req = "R3";
    do_load(32'h1010_0000, 8'h20);
    cyc(80);
    do_load(32'h0A34_5678, 8'hC0);
    cyc(80);

    // R4: loads at random points while running, some back-to-back
    req = "R4";
    for (int k = 0; k < 40; k++) begin
      do_load({$urandom_range(0, 8'h7F), 24'(($urandom))}, 8'($urandom));
      cyc($urandom_range(0, 12));
    end
    for (int k = 0; k < 20; k++) do_load(32'hF000_0000 | 32'($urandom_range(0, 255)), 8'($urandom));
    cyc(20);

    // R7: all-ones threshold
    req = "R7";
    do_load(32'h0777_7777, 8'hFF);
    cyc(40);
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #3;
      chk(wave_w == 1'b1, "R7 constant high", wave_w, 1);
    end

    // R5: enable toggling with loads
    req = "R5";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      en = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) begin
        freq_word = {$urandom_range(0, 8'h3F), 24'($urandom)}; thr_word = 8'($urandom); load = 1'b1;
      end else load = 1'b0;
    end
    @(negedge clk); load = 1'b0; en = 1'b0;
    @(posedge clk); #3;
    chk(wave_w == 0 && wrap_w == 0, "R5 disabled outputs", {wave_w, wrap_w}, 0);

    // R8: zero frequency applied while disabled
    req = "R8";
    do_load(32'h0000_0000, 8'h80);
    @(negedge clk); en = 1'b1;
    @(posedge clk); #3; lvl = wave_w;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #3;
      chk(wrap_w == 0 && wave_w == lvl, "R8 frozen", {wave_w, wrap_w}, {lvl, 1'b0});
    end

    // R6: reset during run
    req = "R6";
    @(negedge clk); en = 1'b0;
    do_load(32'h3000_0000, 8'h40);
    @(negedge clk); en = 1'b1;
    cyc(10);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #3;
    chk(wave_w == 0 && wrap_w == 0 && wave_n == 0, "R6 mid-run reset", {wave_w, wrap_w, wave_n}, 0);
    @(negedge clk); rst = 1'b0;
    cyc(30);
    finish_up();
  end
endmodule